// File: doc/BRIEF.md
# Buffered Video Memory Data Port

This block gives a processor byte-wide access to a 14-bit video address space. Two consecutive writes to the address port load a 14-bit pointer. The first write sets the high byte and the second sets the low byte. Each access to the data port then reads or writes at that pointer, and the pointer moves forward by 1 or by 32 after every accepted data access. A read of the status port returns zero. Its only effect is to send the next address write back to the high byte.

Data reads below the palette page are delayed by one read. The processor gets what an earlier access left in a one-byte read buffer, and a background bus cycle then refills that buffer from external memory. The top page (0x3F00–0x3FFF) is served by a 32-entry internal palette store, which answers at once. The palette store is mirrored every 32 bytes. A palette-page read still runs an external read, at the address with bit 12 cleared (0x2Fxx), and the result goes into the buffer. A palette-page write updates the store and runs a bus cycle with the write strobe held inactive.

A small sequencer runs each bus cycle. It has three states. SEQ_IDLE waits for an accepted data access and goes to SEQ_LATCH. SEQ_LATCH drives the address with the latch strobe high for one clock and always goes to SEQ_STROBE. SEQ_STROBE holds the read or write strobe low for STROBE_CYCLES clocks and then returns to SEQ_IDLE. On the last SEQ_STROBE clock of a read, the buffer captures the bus data. `busy` is high in every state except SEQ_IDLE.

Top module: `vdp_port`

## Requirements
- R1: After reset: pointer 0x0000, next address write takes the high byte, read buffer 0x00, `busy` low, `vm_ale` low, `vm_rd_n` and `vm_wr_n` high.
- R2: Port select `cpu_reg` 2'd1 is the address port. The first write loads pointer bits 13:8 from `cpu_wdata[5:0]`, the second loads bits 7:0, and the two alternate.
- R3: A read with `cpu_reg` 2'd0 (status) returns 0x00 with `cpu_rvalid` one clock later. It also makes the next address write load the high byte.
- R4: A data read (`cpu_reg` 2'd2) at a pointer in 0x0000–0x3EFF returns the buffer's previous contents one clock after the request. The buffer is then refilled from the bus at that pointer.
- R5: A data read at a pointer in 0x3F00–0x3FFF returns the palette entry indexed by pointer bits 4:0, so 0x3F20–0x3FFF mirror 0x3F00–0x3F1F.
- R6: A palette-page access runs its bus cycle at the pointer with bit 12 cleared (0x2F00–0x2FFF). For a read, the byte fetched there goes into the buffer and is returned by the next buffered read.
- R7: Whether a read is direct or buffered depends on the pointer at the moment of that read, including a pointer reached by incrementing.
- R8: An accepted data access drives `vm_ale` high for exactly one clock, in the clock after the request, with `vm_addr` valid. The address stays stable while `vm_rd_n` (reads, any address) or `vm_wr_n` is low for STROBE_CYCLES clocks. `busy` is high through the whole cycle.
- R9: A data write below 0x3F00 drives `vm_wr_n` low with `vm_wdata` equal to the written byte. A data write in 0x3F00–0x3FFF updates the palette and runs the cycle with `vm_wr_n` held high.
- R10: After each accepted data access the pointer advances by 32 when `step32` is high and by 1 otherwise, wrapping from 0x3FFF to 0x0000.
- R11: A data-port access requested while `busy` is high is ignored. It produces no read data, no bus cycle and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-clock access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 2 | Port select: 0 status, 1 address, 2 data, 3 unused |
| cpu_wdata | input | 8 | Write byte |
| step32 | input | 1 | Pointer step select (1 → 32, 0 → 1) |
| cpu_rdata | output | 8 | Read byte |
| cpu_rvalid | output | 1 | Read byte valid pulse |
| busy | output | 1 | Background bus cycle in progress |
| vm_addr | output | 14 | External bus address |
| vm_ale | output | 1 | Address latch strobe, active high |
| vm_rd_n | output | 1 | Read strobe, active low |
| vm_wr_n | output | 1 | Write strobe, active low |
| vm_wdata | output | 8 | External write data |
| vm_rdata | input | 8 | External read data |

## Verification
Assertions check the bus protocol on every cycle. They cover the one-clock latch pulse, a stable address while a strobe is low, strobes that are never both low and only appear while busy, and the rule that no bus address ever lands in the palette page. They also check that every accepted data access starts a cycle and that every accepted read produces data. Other behaviours depend on history, and only the bench scenarios show them. These are the one-read lag, the switch between buffered and direct reads as the pointer crosses 0x3F00 or wraps past 0x3FFF, the buffer refill under the palette, the toggle reset done by a status read, and the dropping of requests made while busy.

// File: rtl/vdp_pkg.sv
package vdp_pkg;

    localparam int VADDR_W = 14;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LATCH,
        SEQ_STROBE
    } seq_state_t;

    localparam logic [1:0] PORT_STATUS = 2'd0;
    localparam logic [1:0] PORT_ADDR   = 2'd1;
    localparam logic [1:0] PORT_DATA   = 2'd2;

    // true when the pointer lies in the palette page
    function automatic logic in_palette(input logic [VADDR_W-1:0] a);
        return a[VADDR_W-1:8] == 6'h3F;
    endfunction

endpackage

// File: rtl/vdp_addr_reg.sv
module vdp_addr_reg #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_toggle,
    input  logic          ld,
    input  logic [7:0]    ld_data,
    input  logic          adv,
    input  logic          step32,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP_LO = AW'(1);
    localparam logic [AW-1:0] STEP_HI = AW'(32);

    logic lo_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr    <= '0;
            lo_next <= 1'b0;
        end else begin
            if (clr_toggle) begin
                lo_next <= 1'b0;
            end else if (ld) begin
                lo_next <= ~lo_next;
                if (lo_next)
                    addr <= {addr[AW-1:8], ld_data};
                else
                    addr <= AW'({ld_data, addr[7:0]});
            end
            if (adv)
                addr <= addr + (step32 ? STEP_HI : STEP_LO);
        end
    end
endmodule

// File: rtl/vdp_palette.sv
module vdp_palette #(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/vdp_bus_seq.sv
module vdp_bus_seq
    import vdp_pkg::*;
#(
    parameter int STROBE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_wr,
    input  logic start_inhibit,
    output logic busy,
    output logic ale,
    output logic rd_n,
    output logic wr_n,
    output logic capture
);
    localparam int CW = $clog2(STROBE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STROBE_CYCLES - 1);

    seq_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic op_wr_q, op_inh_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (start) state_d = SEQ_LATCH;
            SEQ_LATCH:  state_d = SEQ_STROBE;
            SEQ_STROBE: if (cnt_q == LAST) state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            cnt_q    <= '0;
            op_wr_q  <= 1'b0;
            op_inh_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_IDLE && start) begin
                op_wr_q  <= start_wr;
                op_inh_q <= start_inhibit;
            end
            cnt_q <= (state_q == SEQ_STROBE) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        busy    = 1'b1;
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        capture = 1'b0;
        unique case (state_q)
            SEQ_IDLE:   busy = 1'b0;
            SEQ_LATCH:  ale  = 1'b1;
            SEQ_STROBE: begin
                rd_n    = op_wr_q;
                wr_n    = ~op_wr_q | op_inh_q;
                capture = ~op_wr_q & (cnt_q == LAST);
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/vdp_port.sv
module vdp_port
    import vdp_pkg::*;
#(
    parameter int STROBE_CYCLES = 2,
    parameter int PAL_DEPTH     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [1:0]         cpu_reg,
    input  logic [7:0]         cpu_wdata,
    input  logic               step32,
    output logic [7:0]         cpu_rdata,
    output logic               cpu_rvalid,
    output logic               busy,
    output logic [VADDR_W-1:0] vm_addr,
    output logic               vm_ale,
    output logic               vm_rd_n,
    output logic               vm_wr_n,
    output logic [7:0]         vm_wdata,
    input  logic [7:0]         vm_rdata
);
    localparam int PIW = $clog2(PAL_DEPTH);
    localparam logic [VADDR_W-1:0] PAL_BUS_MASK = 14'h2FFF;

    logic [VADDR_W-1:0] ptr;
    logic [7:0] pal_rd, rbuf;
    logic data_go, addr_wr, stat_rd, pal_hit, capture;

    assign data_go = cpu_req && cpu_reg == PORT_DATA && !busy;
    assign addr_wr = cpu_req && cpu_reg == PORT_ADDR && cpu_we;
    assign stat_rd = cpu_req && cpu_reg == PORT_STATUS && !cpu_we;
    assign pal_hit = in_palette(ptr);

    vdp_addr_reg #(.AW(VADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_toggle (stat_rd),
        .ld         (addr_wr),
        .ld_data    (cpu_wdata),
        .adv        (data_go),
        .step32     (step32),
        .addr       (ptr)
    );

    vdp_palette #(.DEPTH(PAL_DEPTH)) u_pal (
        .clk   (clk),
        .we    (data_go && cpu_we && pal_hit),
        .idx   (ptr[PIW-1:0]),
        .wdata (cpu_wdata),
        .rdata (pal_rd)
    );

    vdp_bus_seq #(.STROBE_CYCLES(STROBE_CYCLES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (data_go),
        .start_wr      (cpu_we),
        .start_inhibit (pal_hit),
        .busy          (busy),
        .ale           (vm_ale),
        .rd_n          (vm_rd_n),
        .wr_n          (vm_wr_n),
        .capture       (capture)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vm_addr    <= '0;
            vm_wdata   <= '0;
            rbuf       <= '0;
            cpu_rdata  <= '0;
            cpu_rvalid <= 1'b0;
        end else begin
            cpu_rvalid <= 1'b0;
            if (data_go) begin
                vm_addr  <= pal_hit ? (ptr & PAL_BUS_MASK) : ptr;
                vm_wdata <= cpu_wdata;
                if (!cpu_we) begin
                    cpu_rdata  <= pal_hit ? pal_rd : rbuf;
                    cpu_rvalid <= 1'b1;
                end
            end else if (stat_rd) begin
                cpu_rdata  <= 8'h00;
                cpu_rvalid <= 1'b1;
            end
            if (capture)
                rbuf <= vm_rdata;
        end
    end
endmodule

// File: rtl/vdp_port_chk.sv
module vdp_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic [1:0]  cpu_reg,
    input logic        cpu_rvalid,
    input logic        busy,
    input logic [13:0] vm_addr,
    input logic        vm_ale,
    input logic        vm_rd_n,
    input logic        vm_wr_n
);
    logic go;
    assign go = cpu_req && cpu_reg == 2'd2 && !busy;

    // R8
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vm_ale |=> !vm_ale);
    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_ale || !vm_rd_n || !vm_wr_n) |=> (vm_ale || (vm_rd_n && vm_wr_n) || $stable(vm_addr)));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!vm_rd_n && !vm_wr_n));
    // R8
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vm_rd_n || !vm_wr_n || vm_ale) |-> busy);
    // R8
    start_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> vm_ale);
    // R4
    read_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !cpu_we) |=> cpu_rvalid);
    // R6
    no_pal_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vm_ale |-> vm_addr[13:8] != 6'h3F);
    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !vm_ale) |=> !vm_ale);
endmodule

bind vdp_port vdp_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_reg    (cpu_reg),
    .cpu_rvalid (cpu_rvalid),
    .busy       (busy),
    .vm_addr    (vm_addr),
    .vm_ale     (vm_ale),
    .vm_rd_n    (vm_rd_n),
    .vm_wr_n    (vm_wr_n)
);

// File: tb/vdp_port_bench.sv
module vdp_port_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0, step32 = 1'b0;
    logic [1:0] cpu_reg = 2'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata, vm_wdata, vm_rdata;
    logic cpu_rvalid, busy, vm_ale, vm_rd_n, vm_wr_n;
    logic [13:0] vm_addr;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_of(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b01};
    endfunction
    assign vm_rdata = mem_of(vm_addr);

    vdp_port u_vdp_port (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata), .step32(step32),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .busy(busy),
        .vm_addr(vm_addr), .vm_ale(vm_ale), .vm_rd_n(vm_rd_n),
        .vm_wr_n(vm_wr_n), .vm_wdata(vm_wdata), .vm_rdata(vm_rdata)
    );

    // reference model
    logic [13:0] m_ptr = '0;
    logic        m_lo = 1'b0;
    logic [7:0]  m_buf = '0;
    logic [7:0]  m_pal [32];

    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every read reply
    always @(negedge clk) begin
        if (rst_n && cpu_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected reply", {24'd0, cpu_rdata}, 32'hFFFF_FFFF);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, {24'd0, cpu_rdata}, {24'd0, e});
            end
        end
    end

    task automatic poke(input logic [1:0] r, input logic we, input logic [7:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_reg = r; cpu_we = we; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic status_rd(input string t);
        exp_q.push_back(8'h00); tag_q.push_back(t);
        poke(2'd0, 1'b0, 8'h00);
        m_lo = 1'b0;
    endtask

    task automatic addr_byte(input logic [7:0] d);
        poke(2'd1, 1'b1, d);
        if (m_lo) m_ptr[7:0] = d; else m_ptr[13:8] = d[5:0];
        m_lo = ~m_lo;
    endtask

    task automatic set_ptr(input logic [13:0] a);
        addr_byte({2'b00, a[13:8]});
        addr_byte(a[7:0]);
    endtask

    function automatic logic pal(input logic [13:0] a);
        return a[13:8] == 6'h3F;
    endfunction

    task automatic data_rd(input string t);
        logic [13:0] ba;
        ba = pal(m_ptr) ? (m_ptr & 14'h2FFF) : m_ptr;
        exp_q.push_back(pal(m_ptr) ? m_pal[m_ptr[4:0]] : m_buf);
        tag_q.push_back(t);
        poke(2'd2, 1'b0, 8'h00);
        check({t, " R8 ale"}, {31'd0, vm_ale}, 32'd1);
        check({t, " R6 bus addr"}, {18'd0, vm_addr}, {18'd0, ba});
        @(negedge clk);
        check({t, " R8 rd strobe"}, {30'd0, vm_rd_n, vm_wr_n}, 32'b01);
        wait_idle();
        m_buf = mem_of(ba);
        m_ptr = m_ptr + (step32 ? 14'd32 : 14'd1);
    endtask

    task automatic data_wr(input string t, input logic [7:0] d);
        logic p;
        p = pal(m_ptr);
        poke(2'd2, 1'b1, d);
        check({t, " R8 ale"}, {31'd0, vm_ale}, 32'd1);
        @(negedge clk);
        check({t, " R9 strobes"}, {30'd0, vm_rd_n, vm_wr_n}, {30'd0, 1'b1, p});
        if (!p) check({t, " R9 wdata"}, {24'd0, vm_wdata}, {24'd0, d});
        wait_idle();
        if (p) m_pal[m_ptr[4:0]] = d;
        m_ptr = m_ptr + (step32 ? 14'd32 : 14'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 idle", {28'd0, busy, vm_ale, vm_rd_n, vm_wr_n}, 32'b0011);
        data_rd("R1 buffer zero"); // pointer 0 -> buffer reset value

        status_rd("R3 status zero");
        set_ptr(14'h2005);                         // R2
        data_rd("R4 lagged read");
        data_rd("R4 refilled buffer");
        check("R2 R10 ptr via bus", {18'd0, vm_addr}, 32'h2006);

        set_ptr(14'h2100);
        data_wr("R9 plain write", 8'h5A);

        set_ptr(14'h3F00);
        for (int i = 0; i < 32; i++) data_wr("R9 palette write", 8'(i * 7 + 3));

        set_ptr(14'h3F20);
        data_rd("R5 mirror direct");
        set_ptr(14'h3EFF);
        data_rd("R6 buffer under palette");
        data_rd("R7 direct at 0x3F00");
        data_rd("R7 direct at 0x3F01");

        addr_byte(8'h12);
        status_rd("R3 status zero 2");
        set_ptr(14'h3F05);
        data_rd("R3 toggle reset read");

        step32 = 1'b1;
        set_ptr(14'h2000);
        data_rd("R10 step32 a");
        data_rd("R10 step32 b");
        data_rd("R10 step32 c");
        step32 = 1'b0;

        set_ptr(14'h3FFF);
        data_rd("R10 top direct");
        data_rd("R10 wrapped buffered");
        data_rd("R10 after wrap");

        set_ptr(14'h2200);
        exp_q.push_back(m_buf); tag_q.push_back("R11 first read");
        poke(2'd2, 1'b0, 8'h00);
        poke(2'd2, 1'b0, 8'h00);                   // busy: dropped
        wait_idle();
        m_buf = mem_of(14'h2200);
        m_ptr = 14'h2201;
        data_rd("R11 pointer moved once");
        repeat (4) @(negedge clk);
        check("R11 queue drained", exp_q.size(), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule